// File: doc/BRIEF.md
# Watchdog and Reset Supervisor Core

This block is the digital control core of a processor power supervisor. An external comparator gives it a synchronous low-supply flag. From that flag it holds the processor in reset for as long as the supply is low, and then for a fixed stretch after the supply recovers. It also runs a watchdog on a service input. Every rising or falling edge of that input restarts the count. If the input stays at one level for a whole time-out period, the watchdog status output drops and a full reset pulse is issued. This repeats once per period until the input is serviced again.

All durations are counted in ticks of a timebase enable on the system clock. There are two watchdog periods, short and long, chosen by a select input. The long period is always used for the first window after any reset. A chip-enable path for external RAM is passed straight through, but it is forced inactive while the supply is low. An enable input stands in for the disabled state of a three-level watchdog pin.

Top module: `sup_core`

## Requirements
- R1: While `rst` or `low_line` is high, `reset_n` is 0. After `rst` the outputs are `reset_n`=0, `reset`=1, `wdo_n`=1, and `ce_out_n`=1 while `low_line` is 1.
- R2: Once `low_line` is 0, `reset_n` rises after the RST_TICKS-th clock edge that has `tick`=1. Edges with `tick`=0 do not advance the stretch.
- R3: `reset` is always the inverse of `reset_n`.
- R4: Each rising or falling edge of `wdi` restarts the watchdog count. The restart acts at the third clock edge after the input changes: two synchronizer stages, then edge detection.
- R5: If `wdi` does not change for a full period while `wd_en`=1 and reset is released, then on the period's final tick `wdo_n` goes to 0 and `reset_n` goes to 0 for RST_TICKS ticks. With no service, this repeats once per period after each release.
- R6: `wdo_n` returns to 1 on the edge where a `wdi` transition is acted on, and on the edge after `low_line` is sampled high.
- R7: With `wd_en`=0 the watchdog count is held at zero, and no watchdog reset or `wdo_n` fall occurs.
- R8: After the first service following a reset, `short_sel`=1 selects SHORT_TICKS and `short_sel`=0 selects LONG_TICKS.
- R9: From any reset until the first acted-on `wdi` edge, the period is LONG_TICKS whatever the value of `short_sel`.
- R10: `ce_out_n` is 1 while `low_line` is 1. Otherwise it equals `ce_in_n` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| low_line | input | 1 | Supply below threshold, synchronous |
| tick | input | 1 | Single-cycle timebase enable |
| wdi | input | 1 | Watchdog service input, asynchronous |
| wd_en | input | 1 | Watchdog enable |
| short_sel | input | 1 | 1 selects the short period |
| ce_in_n | input | 1 | RAM chip-enable from the decoder, active low |
| reset_n | output | 1 | Processor reset, active low |
| reset | output | 1 | Processor reset, active high |
| wdo_n | output | 1 | Watchdog expired, active low |
| ce_out_n | output | 1 | Gated RAM chip-enable, active low |

## Verification
The bench builds the block with RST_TICKS=4, LONG_TICKS=30 and SHORT_TICKS=10. This brings repeated watchdog resets, the return to the long period after each reset, and a short-period expiry within a few hundred cycles. The default sizes would need thousands of cycles per window. Holding `tick` high makes every window an exact cycle count. One phase holds `tick` low to show that the stretch freezes. The service interval is 6 cycles, below the short period, so the release point after the last edge pins the three-edge synchronizer delay.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_e;

    typedef struct packed {
        logic level;
        logic toggled;
    } wdi_sample_t;

    function automatic int unsigned pick_period(
        input logic        force_long,
        input logic        short_sel,
        input int unsigned long_t,
        input int unsigned short_t
    );
        return (force_long || !short_sel) ? long_t : short_t;
    endfunction

endpackage

// File: rtl/sup_wdi_sync.sv
module sup_wdi_sync #(
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wdi,
    output sup_pkg::wdi_sample_t smp
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], wdi};
    end

    always_comb begin
        smp.level   = pipe[STAGES-1];
        smp.toggled = pipe[STAGES] ^ pipe[STAGES-1];
    end
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer #(
    parameter int LONG_TICKS  = 4032,
    parameter int SHORT_TICKS = 960
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic wd_en,
    input  logic short_sel,
    input  logic hold,
    input  logic toggled,
    output logic timeout
);
    localparam int WCW = $clog2(LONG_TICKS + 1);

    logic [WCW-1:0] wcnt;
    logic [WCW-1:0] limit_m1;
    logic           force_long;

    always_comb begin
        limit_m1 = WCW'(sup_pkg::pick_period(force_long, short_sel,
                        LONG_TICKS, SHORT_TICKS) - 1);
        timeout  = tick && wd_en && !hold && !toggled && (wcnt >= limit_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt       <= '0;
            force_long <= 1'b1;
        end else begin
            if (hold)         force_long <= 1'b1;
            else if (toggled) force_long <= 1'b0;
            if (hold || !wd_en || toggled || timeout) wcnt <= '0;
            else if (tick)                            wcnt <= wcnt + 1'b1;
        end
    end

    p_disabled_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> (wcnt == '0));
    p_edge_restart_r4: assert property (@(posedge clk) disable iff (rst)
        toggled |=> (wcnt == '0));
    p_long_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        hold |=> force_long);
endmodule

// File: rtl/sup_rst_stretch.sv
module sup_rst_stretch #(
    parameter int RST_TICKS = 35
) (
    input  logic clk,
    input  logic rst,
    input  logic low_line,
    input  logic tick,
    input  logic timeout,
    output logic hold
);
    import sup_pkg::*;
    localparam int RCW = $clog2(RST_TICKS + 1);

    hold_state_e    state;
    logic [RCW-1:0] rcnt;

    always_ff @(posedge clk) begin
        if (rst || low_line || timeout) begin
            state <= ST_HOLD;
            rcnt  <= '0;
        end else if (state == ST_HOLD && tick) begin
            if (rcnt == RCW'(RST_TICKS - 1)) begin
                state <= ST_RUN;
                rcnt  <= '0;
            end else begin
                rcnt <= rcnt + 1'b1;
            end
        end
    end

    assign hold = (state == ST_HOLD);

    p_hold_on_low_r1: assert property (@(posedge clk) disable iff (rst)
        low_line |=> hold);
    p_frozen_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (hold && !tick) |=> hold);
endmodule

// File: rtl/sup_core.sv
module sup_core #(
    parameter int RST_TICKS   = 35,
    parameter int LONG_TICKS  = 4032,
    parameter int SHORT_TICKS = 960,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic low_line,
    input  logic tick,
    input  logic wdi,
    input  logic wd_en,
    input  logic short_sel,
    input  logic ce_in_n,
    output logic reset_n,
    output logic reset,
    output logic wdo_n,
    output logic ce_out_n
);
    sup_pkg::wdi_sample_t smp;
    logic hold;
    logic timeout;

    sup_wdi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .wdi(wdi), .smp(smp)
    );

    sup_wd_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_timer (
        .clk(clk), .rst(rst), .tick(tick), .wd_en(wd_en),
        .short_sel(short_sel), .hold(hold), .toggled(smp.toggled),
        .timeout(timeout)
    );

    sup_rst_stretch #(.RST_TICKS(RST_TICKS)) u_stretch (
        .clk(clk), .rst(rst), .low_line(low_line), .tick(tick),
        .timeout(timeout), .hold(hold)
    );

    always_ff @(posedge clk) begin
        if (rst)                            wdo_n <= 1'b1;
        else if (low_line || smp.toggled)   wdo_n <= 1'b1;
        else if (timeout)                   wdo_n <= 1'b0;
    end

    assign reset_n  = !hold;
    assign reset    = hold;
    assign ce_out_n = low_line | ce_in_n;

    p_wdo_fall_resets_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(wdo_n) |-> !reset_n);
    p_wdo_set_on_low_r6: assert property (@(posedge clk) disable iff (rst)
        low_line |=> wdo_n);
    p_release_needs_supply_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_n) |-> !$past(low_line));
endmodule

// File: tb/sup_core_tb.sv
module sup_core_tb;
    localparam int RST   = 4;
    localparam int LONG  = 30;
    localparam int SHORT = 10;

    logic clk = 1'b0;
    logic rst, low_line, tick, wdi, wd_en, short_sel, ce_in_n;
    logic reset_n, reset, wdo_n, ce_out_n;

    typedef struct {
        int    cyc;
        int    sig;
        logic  val;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   nchk = 0;
    int   nfail = 0;
    logic mon_on = 1'b0;
    logic prev_rn, prev_wd;
    logic done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sup_core #(.RST_TICKS(RST), .LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) u_dut (
        .clk(clk), .rst(rst), .low_line(low_line), .tick(tick), .wdi(wdi),
        .wd_en(wd_en), .short_sel(short_sel), .ce_in_n(ce_in_n),
        .reset_n(reset_n), .reset(reset), .wdo_n(wdo_n), .ce_out_n(ce_out_n)
    );

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push(input int c, input int s, input logic v, input string req);
        exp_t e;
        e.cyc = c; e.sig = s; e.val = v; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic take_event(input int s, input logic v);
        exp_t e;
        nchk++;
        if (exp_q.size() == 0) begin
            nfail++;
            $display("FAIL unexpected: sig %0d actual %0b at cyc %0d expected no change", s, v, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.sig != s || e.val != v || e.cyc != cyc) begin
                nfail++;
                $display("FAIL %s: sig %0d val %0b cyc %0d expected sig %0d val %0b cyc %0d",
                         e.req, s, v, cyc, e.sig, e.val, e.cyc);
            end
        end
        // R3: inverse output checked at every transition
        chk(reset == !reset_n, "R3 inverse", int'(reset), int'(!reset_n));
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (reset_n != prev_rn) take_event(0, reset_n);
                if (wdo_n   != prev_wd) take_event(1, wdo_n);
                prev_rn = reset_n;
                prev_wd = wdo_n;
                while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                    nchk++; nfail++;
                    $display("FAIL %s: missing sig %0d val %0b expected at cyc %0d, now %0d",
                             exp_q[0].req, exp_q[0].sig, exp_q[0].val, exp_q[0].cyc, cyc);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: run hung at cyc %0d expected end", cyc);
            report();
        end
    end

    initial begin
        int c, c2, cl, r2v, r3;
        rst = 1'b1; low_line = 1'b1; tick = 1'b1; wdi = 1'b0;
        wd_en = 1'b0; short_sel = 1'b0; ce_in_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(reset_n == 1'b0, "R1 reset_n after rst", int'(reset_n), 0);
        chk(reset == 1'b1, "R1 reset after rst", int'(reset), 1);
        chk(wdo_n == 1'b1, "R1 wdo_n after rst", int'(wdo_n), 1);
        chk(ce_out_n == 1'b1, "R1 R10 ce_out_n under low_line", int'(ce_out_n), 1);
        rst = 1'b0;
        prev_rn = reset_n; prev_wd = wdo_n; mon_on = 1'b1;
        repeat (6) @(negedge clk);
        chk(reset_n == 1'b0, "R1 held while low_line", int'(reset_n), 0);

        // R2: stretch after supply recovery
        c = cyc; low_line = 1'b0;
        push(c + RST, 0, 1'b1, "R2 release");
        wait_until(c + RST + 2);

        // R10: pass-through
        ce_in_n = 1'b0; #1;
        chk(ce_out_n == 1'b0, "R10 pass low", int'(ce_out_n), 0);
        ce_in_n = 1'b1; #1;
        chk(ce_out_n == 1'b1, "R10 pass high", int'(ce_out_n), 1);

        // R5 R9: unserviced watchdog, long period forced despite short_sel
        @(negedge clk);
        c = cyc; short_sel = 1'b1; wd_en = 1'b1;
        push(c + LONG, 0, 1'b0, "R9 R5 first timeout");
        push(c + LONG, 1, 1'b0, "R5 wdo fall");
        push(c + LONG + RST, 0, 1'b1, "R5 pulse end");
        push(c + 2*LONG + RST, 0, 1'b0, "R5 repeat timeout");
        r2v = c + 2*LONG + 2*RST;
        push(r2v, 0, 1'b1, "R5 repeat end");
        wait_until(r2v + 2);

        // R4 R6 R8: service every 6 cycles, then stop
        c2 = cyc;
        cl = c2 + 18;
        push(c2 + 3, 1, 1'b1, "R6 wdo set on edge");
        push(cl + 3 + SHORT, 0, 1'b0, "R8 R4 short timeout");
        push(cl + 3 + SHORT, 1, 1'b0, "R8 wdo fall");
        r3 = cl + 3 + SHORT + RST;
        push(r3, 0, 1'b1, "R8 pulse end");
        push(r3 + LONG, 0, 1'b0, "R9 long after reset");
        push(r3 + LONG + RST, 0, 1'b1, "R9 pulse end");
        for (int i = 0; i < 4; i++) begin
            wait_until(c2 + 6*i);
            wdi = ~wdi;
        end
        wait_until(r3 + LONG + RST + 1);

        // R7: disabled watchdog stays quiet
        wd_en = 1'b0;
        repeat (2*LONG) @(negedge clk);
        chk(reset_n == 1'b1, "R7 no reset while disabled", int'(reset_n), 1);
        chk(wdo_n == 1'b0, "R7 wdo unchanged while disabled", int'(wdo_n), 0);

        // R1 R6 R10: low line asserts
        c = cyc; low_line = 1'b1;
        push(c + 1, 0, 1'b0, "R1 low_line reset");
        push(c + 1, 1, 1'b1, "R6 wdo set on low_line");
        ce_in_n = 1'b0; #1;
        chk(ce_out_n == 1'b1, "R10 forced high", int'(ce_out_n), 1);
        wait_until(c + 4);
        ce_in_n = 1'b1;

        // R2: no ticks, no release
        tick = 1'b0; low_line = 1'b0;
        repeat (20) @(negedge clk);
        chk(reset_n == 1'b0, "R2 frozen without tick", int'(reset_n), 0);
        c = cyc; tick = 1'b1;
        push(c + RST, 0, 1'b1, "R2 release after ticks");
        wait_until(c + RST + 3);

        chk(exp_q.size() == 0, "R5 all expected events seen", exp_q.size(), 0);
        done = 1'b1;
        report();
    end
endmodule